// File: doc/BRIEF.md
# Break-Before-Make Channel Select Sequencer

This block turns a 4-bit channel control word into one-hot enables for a bank of analog multiplexer switches. The word carries an enable bit and a 3-bit channel code. A one-cycle update strobe tells the block that a new word has been accepted upstream. On every update the block first opens all switches. It then holds them open for a programmable number of system clocks, and only after that closes the switch (or the pair of switches) that the new word selects.

Two decode modes are available. In single-ended mode the three code bits pick one of eight enables. In pair mode the upper two code bits pick one of four leg pairs, and each pair drives two neighbouring enables. The mode comes from an input that is captured only while reset is asserted, so it stays fixed for the whole time the block is running.

Top module: `bbm_chan_seq`

## Requirements
- R1: An update whose enable bit `ctl_word[3]` is 0 leaves every `sw_en` bit at 0, with no later closing, until the next update arrives.
- R2: In single-ended mode, an update with `ctl_word[3]`=1 selects channel i = `ctl_word[2:0]` and eventually drives only `sw_en[i]` high (000 selects bit 0, 111 selects bit 7).
- R3: In pair mode, an update with `ctl_word[3]`=1 selects pair k = `ctl_word[2:1]` and drives `sw_en[2k]` and `sw_en[2k+1]` high. `ctl_word[0]` has no effect.
- R4: In the clock cycle after the rising edge at which `upd` is sampled high, every `sw_en` bit is 0, whatever was selected before.
- R5: After the update edge, `sw_en` stays all-zero for exactly `DEAD_CYC` cycles (minimum 1). The new selection appears on the `DEAD_CYC`-th rising edge after the update edge.
- R6: An update that arrives while the dead interval is running restarts the interval from that update, and the newest word is the one that closes.
- R7: At no time is more than one enable high in single-ended mode, or more than one aligned pair high in pair mode.
- R8: `pair_mode` (0 = single-ended, 1 = pair) is captured on every clock while `rst` is high. Changing it outside reset has no effect on decoding.
- R9: While and after synchronous reset, every `sw_en` bit is 0 and no closing is pending. Changes on `ctl_word` without `upd` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pair_mode | input | 1 | Decode mode, sampled only during reset (1 = pair) |
| ctl_word | input | 4 | Enable bit [3] and channel code [2:0] |
| upd | input | 1 | One-cycle strobe: load `ctl_word` and start the sequence |
| sw_en | output | 8 | Registered switch enables |

## Verification
The hardest case to reach from the ports is an update that lands inside a dead interval that is already running. It has to come exactly one cycle after the previous strobe, and the test must show that the first word never closes. The bench sets this up by issuing a second strobe on the cycle right after the first. It then checks every cycle of the restarted interval and confirms that only the second word's enable appears. Capture of the decode mode is reached by toggling `pair_mode` after reset is released and confirming that the single-ended decode still applies.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_PAIR   = 1'b1
  } dec_mode_t;

  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_DEAD = 1'b1
  } tmr_state_t;
endpackage

// File: rtl/bbm_decode.sv
module bbm_decode #(
  parameter int N_CH  = 8,
  parameter int SEL_W = $clog2(N_CH)
) (
  input  bbm_pkg::dec_mode_t mode,
  input  logic               en_bit,
  input  logic [SEL_W-1:0]   code,
  output logic [N_CH-1:0]    mask
);
  // A pair is the code with its lowest bit dropped
  logic [SEL_W-1:0] pair_base;
  assign pair_base = {code[SEL_W-1:1], 1'b0};

  for (genvar i = 0; i < N_CH; i++) begin : g_bit
    localparam logic [SEL_W-1:0] IDX  = SEL_W'(i);
    localparam logic [SEL_W-1:0] BASE = SEL_W'(i - (i % 2));
    logic hit_single;
    logic hit_pair;
    assign hit_single = (code == IDX);
    assign hit_pair   = (pair_base == BASE);
    assign mask[i] = en_bit &
                     ((mode == bbm_pkg::MODE_PAIR) ? hit_pair : hit_single);
  end
endmodule

// File: rtl/bbm_dead_timer.sv
module bbm_dead_timer #(
  parameter int DEAD_CYC = 3,
  parameter int CNT_W    = $clog2(DEAD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic arm,
  output logic busy,
  output logic fire
);
  bbm_pkg::tmr_state_t st_q;
  logic [CNT_W-1:0]    cnt_q;

  assign busy = (st_q == bbm_pkg::TMR_DEAD);
  assign fire = busy && !start && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= bbm_pkg::TMR_IDLE;
      cnt_q <= '0;
    end else if (start) begin
      st_q  <= arm ? bbm_pkg::TMR_DEAD : bbm_pkg::TMR_IDLE;
      cnt_q <= CNT_W'(DEAD_CYC);
    end else if (fire) begin
      st_q  <= bbm_pkg::TMR_IDLE;
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(DEAD_CYC))); // R5
  AST_RESTART_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (start && arm) |=> (busy && cnt_q == CNT_W'(DEAD_CYC))); // R6
endmodule

// File: rtl/bbm_switch_reg.sv
module bbm_switch_reg #(
  parameter int N_CH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  bbm_pkg::dec_mode_t mode,
  input  logic               open_all,
  input  logic               close_now,
  input  logic [N_CH-1:0]    next_mask,
  output logic [N_CH-1:0]    sw_q
);
  logic [N_CH-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q   <= '0;
      pend_q <= '0;
    end else if (open_all) begin
      sw_q   <= '0;
      pend_q <= next_mask;
    end else if (close_now) begin
      sw_q   <= pend_q;
    end
  end

  AST_OPEN_ON_UPD: assert property (@(posedge clk) disable iff (rst)
    open_all |=> (sw_q == '0)); // R4
  AST_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
    (mode == bbm_pkg::MODE_SINGLE) |-> $onehot0(sw_q)); // R7
  AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (rst)
    (mode == bbm_pkg::MODE_PAIR) |->
      ($countones(sw_q) == 0 || $countones(sw_q) == 2)); // R7

  for (genvar p = 0; p < N_CH / 2; p++) begin : g_pair_chk
    AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (rst)
      (mode == bbm_pkg::MODE_PAIR) |-> (sw_q[2*p] == sw_q[2*p+1])); // R3
  end
endmodule

// File: rtl/bbm_chan_seq.sv
module bbm_chan_seq #(
  parameter int N_CH     = 8,
  parameter int DEAD_CYC = 3,
  localparam int SEL_W    = $clog2(N_CH),
  localparam int WORD_W   = SEL_W + 1,
  localparam int DEAD_EFF = (DEAD_CYC < 1) ? 1 : DEAD_CYC,
  localparam int CNT_W    = $clog2(DEAD_EFF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pair_mode,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic              upd,
  output logic [N_CH-1:0]   sw_en
);
  bbm_pkg::dec_mode_t mode_q;
  logic [N_CH-1:0]    dec_mask;
  logic               tmr_busy;
  logic               tmr_fire;
  logic               en_bit;

  assign en_bit = ctl_word[WORD_W-1];

  // Mode is only taken while reset is held
  always_ff @(posedge clk) begin
    if (rst) mode_q <= bbm_pkg::dec_mode_t'(pair_mode);
  end

  bbm_decode #(.N_CH(N_CH), .SEL_W(SEL_W)) u_dec (
    .mode   (mode_q),
    .en_bit (en_bit),
    .code   (ctl_word[SEL_W-1:0]),
    .mask   (dec_mask)
  );

  bbm_dead_timer #(.DEAD_CYC(DEAD_EFF), .CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (upd),
    .arm   (en_bit),
    .busy  (tmr_busy),
    .fire  (tmr_fire)
  );

  bbm_switch_reg #(.N_CH(N_CH)) u_sw (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .open_all  (upd),
    .close_now (tmr_fire),
    .next_mask (dec_mask),
    .sw_q      (sw_en)
  );

  // Length of the current all-open run, saturating, for the gap check
  logic [CNT_W-1:0] open_run_q;
  always_ff @(posedge clk) begin
    if (rst) open_run_q <= '0;
    else if (sw_en != '0) open_run_q <= '0;
    else if (open_run_q < CNT_W'(DEAD_EFF)) open_run_q <= open_run_q + CNT_W'(1);
  end

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
    (sw_en != '0 && $past(sw_en) == '0) |-> (open_run_q >= CNT_W'(DEAD_EFF))); // R5
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sw_en == '0 && !tmr_busy && !upd) |=> (sw_en == '0)); // R1
  AST_IDLE_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!tmr_busy && !upd) |=> $stable(sw_en)); // R9
endmodule

// File: tb/bbm_chan_seq_test.sv
module bbm_chan_seq_test;
  localparam int NCH  = 8;
  localparam int DEAD = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pair_mode = 1'b0;
  logic [3:0] ctl_word = 4'h0;
  logic       upd = 1'b0;
  logic [7:0] sw_en;

  int total = 0;
  int bad = 0;
  logic cur_mode = 1'b0;

  always #2.5 clk = ~clk;

  bbm_chan_seq #(.N_CH(NCH), .DEAD_CYC(DEAD)) uut (
    .clk(clk), .rst(rst), .pair_mode(pair_mode),
    .ctl_word(ctl_word), .upd(upd), .sw_en(sw_en)
  );

  // {mode, word, expected enables}
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 4'b1000, 8'h01}, {1'b0, 4'b1001, 8'h02},
    {1'b0, 4'b1010, 8'h04}, {1'b0, 4'b1011, 8'h08},
    {1'b0, 4'b1100, 8'h10}, {1'b0, 4'b1101, 8'h20},
    {1'b0, 4'b1110, 8'h40}, {1'b0, 4'b1111, 8'h80},
    {1'b0, 4'b0101, 8'h00}, {1'b1, 4'b1000, 8'h03},
    {1'b1, 4'b1001, 8'h03}, {1'b1, 4'b1011, 8'h0C},
    {1'b1, 4'b1101, 8'h30}, {1'b1, 4'b1110, 8'hC0},
    {1'b1, 4'b1111, 8'hC0}, {1'b1, 4'b0110, 8'h00}
  };

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst = 1'b1; pair_mode = m; upd = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cur_mode = m;
  endtask

  // Called at a negedge; strobes one update
  task automatic strobe(input logic [3:0] w);
    ctl_word = w; upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  // Full sequence check: zero right after the edge, zero through the dead time, then exp
  task automatic run_update(input logic [3:0] w, input logic [7:0] exp, input string tag);
    strobe(w);
    chk(sw_en, 8'h00, "R4 open after update");
    for (int k = 1; k < DEAD; k++) begin
      @(negedge clk);
      chk(sw_en, 8'h00, "R5 dead interval");
    end
    @(negedge clk);
    chk(sw_en, exp, tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R9: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(sw_en, 8'h00, "R9 reset state");
    rst = 1'b0;
    @(negedge clk);

    // R9: word change without strobe
    ctl_word = 4'b1011;
    repeat (DEAD + 2) @(negedge clk);
    chk(sw_en, 8'h00, "R9 no strobe no effect");

    for (int i = 0; i < NV; i++) begin
      logic       m;
      logic [3:0] w;
      logic [7:0] e;
      string      tag;
      {m, w, e} = VEC[i];
      if (m !== cur_mode) do_reset(m);
      tag = m ? "R3 pair decode" : (w[3] ? "R2 single decode" : "R1 disabled");
      run_update(w, e, tag);
      if (!w[3]) begin
        repeat (DEAD + 2) @(negedge clk);
        chk(sw_en, 8'h00, "R1 stays open");
      end
    end

    // R6: second update one cycle into the dead interval
    do_reset(1'b0);
    run_update(4'b1010, 8'h04, "R2 before restart");
    strobe(4'b1110);
    chk(sw_en, 8'h00, "R6 open on first");
    strobe(4'b1001);
    chk(sw_en, 8'h00, "R6 open on second");
    for (int k = 1; k < DEAD; k++) begin
      @(negedge clk);
      chk(sw_en, 8'h00, "R6 restarted interval");
    end
    @(negedge clk);
    chk(sw_en, 8'h02, "R6 newest word closes");
    repeat (DEAD + 2) @(negedge clk);
    chk(sw_en, 8'h02, "R6 old word never closes");

    // R8: mode pin toggled outside reset
    pair_mode = 1'b1;
    @(negedge clk);
    run_update(4'b1011, 8'h08, "R8 mode held single");
    pair_mode = 1'b0;
    do_reset(1'b1);
    pair_mode = 1'b0;
    run_update(4'b1011, 8'h0C, "R8 mode held pair");

    // R4: reselect the same channel still opens
    strobe(4'b1011);
    chk(sw_en, 8'h00, "R4 same word reopens");
    repeat (DEAD) @(negedge clk);
    chk(sw_en, 8'h0C, "R3 same pair recloses");

    // R9: reset during a dead interval cancels the closing
    strobe(4'b1101);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (DEAD + 2) @(negedge clk);
    chk(sw_en, 8'h00, "R9 reset cancels pending");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule